// File: doc/BRIEF.md
# Per-Pixel Shading Gain Corrector

This block corrects each pixel of a digitized scan line for dark level and sensitivity. A pixel arrives on a valid/ready stream. With it come two side words: a 16-bit offset to remove and a 16-bit gain code to apply. The block removes the offset first. If the offset is larger than the pixel, the difference floors at zero.

The difference is then multiplied by the gain code, read as an unsigned fixed-point number with 2 integer bits and 14 fraction bits. That range covers zero up to just below four times. A code of 16384 passes the difference through unchanged. Smaller codes attenuate it, and a code of zero yields a black pixel.

The product is rounded to the nearest integer and clipped to the largest output code. The result leaves on a registered valid/ready output two cycles after the pixel is accepted. The pipeline holds its contents while the consumer stalls.

Top module: `shading_gain`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: The corrected value is based on `pixIn - offIn` when `offIn < pixIn`, and on 0 otherwise.
- R3: The output equals floor((difference * gainIn + 8192) / 16384), with `gainIn` taken as a 16-bit unsigned value.
- R4: A gain code of 0 gives an output of 0 for every pixel and offset.
- R5: A gain code of 16384 gives an output equal to the difference, clipped to the output width.
- R6: A result above 2^OUT_W - 1 is replaced by 2^OUT_W - 1.
- R7: With `outReady` held at 1, a pixel accepted at a clock edge appears with `outValid` = 1 after exactly the second following edge, and not after the first.
- R8: While `outValid` = 1 and `outReady` = 0, `outValid` and `outData` keep their values on the next edge. No accepted pixel is lost, and pixels leave in the order they entered.
- R9: When both pipeline stages hold pixels and `outReady` = 0, `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Pixel and coefficients are offered |
| inReady | output | 1 | Block can take a pixel this cycle |
| pixIn | input | IN_W | Raw pixel value |
| offIn | input | COEF_W | Offset to subtract |
| gainIn | input | COEF_W | Unsigned gain code, 14 fraction bits |
| outValid | output | 1 | Corrected pixel is present |
| outReady | input | 1 | Consumer takes the pixel this cycle |
| outData | output | OUT_W | Corrected, rounded and clipped pixel |

## Verification
Each accepted pixel becomes due when the second edge after its acceptance has passed, provided the consumer has been ready. The bench therefore checks the latency at the falling edge after one edge, where the output must still be invalid, and again after two edges, where it must be valid. All other results are compared in acceptance order through a queue. An entry is popped only when `outValid` and `outReady` are both high ahead of a rising edge, so a stall only delays the comparison and never changes which value is due. Inputs are driven and handshakes are judged one time unit after each falling edge, away from the sampling edge.

// File: rtl/shade_pkg.sv
package shade_pkg;
  // Strobes from the control to the datapath, one per pipeline stage.
  typedef struct packed {
    logic loadA;  // capture difference and gain
    logic loadB;  // capture rounded, clipped product
  } shadeStrobe_t;
endpackage

// File: rtl/shade_ctrl.sv
module shade_ctrl
  import shade_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output shadeStrobe_t strobe
);
  logic validA, validB;
  logic advA, advB;

  // A stage may advance when it is empty or its successor will move.
  always_comb begin
    advB         = !validB || outReady;
    advA         = !validA || advB;
    inReady      = advA;
    strobe.loadA = advA && inValid;
    strobe.loadB = advB && validA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validA <= 1'b0;
      validB <= 1'b0;
    end else begin
      if (advA) validA <= inValid;
      if (advB) validB <= validA;
    end
  end

  assign outValid = validB;

  // R8: a stalled output keeps its valid flag
  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R9: a full pipeline facing a stalled consumer refuses input
  p_full_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    validA && validB && !outReady |-> !inReady);

  // R7: a pixel moved into the first stage with a free path reaches the output next edge
  p_two_stage_r7: assert property (@(posedge clk) disable iff (!rstN)
    validA && advB |=> outValid);
endmodule

// File: rtl/shade_datapath.sv
module shade_datapath
  import shade_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16,
  parameter int FRAC_BITS = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  shadeStrobe_t      strobe,
  input  logic [IN_W-1:0]   pixIn,
  input  logic [COEF_W-1:0] offIn,
  input  logic [COEF_W-1:0] gainIn,
  output logic [OUT_W-1:0]  outData
);
  localparam int DIFF_W = (IN_W > COEF_W) ? IN_W : COEF_W;
  localparam int PROD_W = DIFF_W + COEF_W + 1;
  localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC_BITS - 1);
  localparam logic [PROD_W-1:0] OUT_MAX  = PROD_W'({OUT_W{1'b1}});
  localparam logic [COEF_W-1:0] UNITY    = COEF_W'(1) << FRAC_BITS;

  logic [DIFF_W-1:0] pixExt, offExt, diffNext, diffReg;
  logic [COEF_W-1:0] gainReg;
  logic [PROD_W-1:0] product, rounded, scaled;
  logic [OUT_W-1:0]  clipped;

  // Stage A: remove offset, floor at zero.
  always_comb begin
    pixExt   = DIFF_W'(pixIn);
    offExt   = DIFF_W'(offIn);
    diffNext = (offExt < pixExt) ? (pixExt - offExt) : '0;
  end

  // Stage B: multiply, round to nearest, drop fraction, clip.
  always_comb begin
    product = PROD_W'(diffReg) * PROD_W'(gainReg);
    rounded = product + HALF_LSB;
    scaled  = rounded >> FRAC_BITS;
    clipped = (scaled > OUT_MAX) ? OUT_W'(OUT_MAX) : OUT_W'(scaled);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffReg <= '0;
      gainReg <= '0;
      outData <= '0;
    end else begin
      if (strobe.loadA) begin
        diffReg <= diffNext;
        gainReg <= gainIn;
      end
      if (strobe.loadB) outData <= clipped;
    end
  end

  // R2: an offset at or above the pixel leaves a zero difference
  p_floor_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadA && (offExt >= pixExt) |=> diffReg == '0);

  // R4: a zero gain code yields a black pixel
  p_zero_gain_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadB && gainReg == '0 |=> outData == '0);

  // R5: unity code passes a difference that fits the output unchanged
  p_unity_gain_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadB && gainReg == UNITY && PROD_W'(diffReg) <= OUT_MAX
      |=> PROD_W'(outData) == $past(PROD_W'(diffReg)));
endmodule

// File: rtl/shading_gain.sv
module shading_gain
  import shade_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16,
  parameter int FRAC_BITS = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [IN_W-1:0]   pixIn,
  input  logic [COEF_W-1:0] offIn,
  input  logic [COEF_W-1:0] gainIn,
  output logic              outValid,
  input  logic              outReady,
  output logic [OUT_W-1:0]  outData
);
  shadeStrobe_t strobe;

  shade_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  shade_datapath #(
    .IN_W      (IN_W),
    .COEF_W    (COEF_W),
    .OUT_W     (OUT_W),
    .FRAC_BITS (FRAC_BITS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pixIn   (pixIn),
    .offIn   (offIn),
    .gainIn  (gainIn),
    .outData (outData)
  );

  // R8: a stalled output keeps its data
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));
endmodule

// File: tb/test_shading_gain.sv
module test_shading_gain;
  localparam int IN_W = 16, COEF_W = 16, OUT_W = 16;
  localparam longint OUT_MAX = (64'd1 << OUT_W) - 1;

  logic clk = 0, rstN = 0;
  logic inValid = 0, outReady = 0;
  logic [IN_W-1:0] pixIn = '0;
  logic [COEF_W-1:0] offIn = '0, gainIn = '0;
  logic inReady, outValid;
  logic [OUT_W-1:0] outData;

  int checks = 0, fails = 0;
  longint expQ[$];
  string  tagQ[$];

  shading_gain i_shading_gain (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .pixIn(pixIn), .offIn(offIn), .gainIn(gainIn),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic longint refModel(longint p, longint o, longint g);
    longint d = (o < p) ? p - o : 0;
    longint r = (d * g + 8192) >> 14;
    return (r > OUT_MAX) ? OUT_MAX : r;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive at falling edge, judge handshakes one unit later for the next rising edge.
  task automatic step(logic iv, longint p, longint o, longint g, logic ordy, string tag);
    @(negedge clk);
    inValid = iv; pixIn = IN_W'(p); offIn = COEF_W'(o); gainIn = COEF_W'(g); outReady = ordy;
    #1;
    if (inValid && inReady) begin
      expQ.push_back(refModel(p, o, g));
      tagQ.push_back(tag);
    end
    if (outValid && outReady) begin
      if (expQ.size() == 0) check("R8 spurious output", 1, 0);
      else check(tagQ.pop_front(), outData, expQ.pop_front());
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [OUT_W-1:0] heldData;
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    #1;
    check("R1 outValid after reset", outValid, 0);
    check("R1 inReady after reset", inReady, 1);

    // R7 latency
    step(1, 1000, 100, 16384, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    check("R7 not valid after one edge", outValid, 0);
    step(0, 0, 0, 0, 1, "R7");
    check("R7 valid after two edges", outValid, 1);
    step(0, 0, 0, 0, 1, "R7");

    // Directed corners
    step(1, 500, 900, 20000, 1, "R2 offset above pixel");
    step(1, 700, 700, 30000, 1, "R2 offset equal pixel");
    step(1, 65535, 0, 0, 1, "R4 zero gain");
    step(1, 12345, 345, 0, 1, "R4 zero gain");
    step(1, 40000, 1, 16384, 1, "R5 unity gain");
    step(1, 65535, 0, 16384, 1, "R5 unity gain max");
    step(1, 65535, 0, 65535, 1, "R6 saturate");
    step(1, 40000, 0, 32768, 1, "R6 saturate 2x");
    step(1, 3, 0, 8192, 1, "R3 round half up");
    step(1, 1, 0, 8191, 1, "R3 round down");
    step(1, 30000, 10000, 12288, 1, "R3 attenuate");
    repeat (3) step(0, 0, 0, 0, 1, "R3");

    // R8 / R9 backpressure
    step(1, 111, 0, 16384, 0, "R8 order a");
    step(1, 222, 0, 16384, 0, "R8 order b");
    step(1, 333, 0, 16384, 0, "R8 order c");
    check("R9 inReady when full", inReady, 0);
    check("R8 valid under stall", outValid, 1);
    heldData = outData;
    step(0, 0, 0, 0, 0, "R8");
    check("R8 valid held", outValid, 1);
    check("R8 data held", outData, heldData);
    step(1, 333, 0, 16384, 1, "R8 order c");
    repeat (4) step(0, 0, 0, 0, 1, "R8");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      longint p = $urandom_range(65535);
      longint o = ($urandom_range(3) == 0) ? $urandom_range(65535) : $urandom_range(2000);
      longint g;
      case ($urandom_range(5))
        0: g = 0;
        1: g = 16384;
        2: g = 65535;
        default: g = $urandom_range(65535);
      endcase
      step($urandom_range(9) < 7, p, o, g, $urandom_range(9) < 7, "R3 random");
    end
    for (int i = 0; i < 10 && expQ.size() != 0; i++) step(0, 0, 0, 0, 1, "R8 drain");
    check("R8 nothing lost", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule